// File: doc/BRIEF.md
# Pin Change Interrupt Detector

This block watches up to four 8-bit groups of input pins and raises an interrupt request when a pin changes level in a direction that software has armed. Every pin has two arming bits, one for low-to-high transitions and one for high-to-low transitions, and a sticky capture bit that records that an armed transition happened. The capture bits of all groups are ORed into one summary bit. The summary bit drives the interrupt request when the global enable bit is set.

Pins arrive asynchronously and pass through an internal synchronizer chain. A transition is found by comparing the synchronized level with the level one clock earlier. Software reads the capture bits and clears the ones it has handled by writing back the value it read ANDed with the inverse of the handled bits. A transition that lands on the same clock as that write is still recorded. There is no streaming data path. The register bus is a plain single-cycle write strobe with a combinational read, and it has no back-pressure.

Register map (address = group index × 4 + kind): kind 0 is the rise-arm register, kind 1 is the fall-arm register, kind 2 is the capture register, and kind 3 of group 0 is the control register. In the control register, bit 0 is the interrupt enable (read/write) and bit 1 is the summary bit (read-only). Kind 3 of any other group reads as zero.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, every arm, capture and control register reads 0x00 and `irq_o` is low.
- R2: A low-to-high transition on a pin whose rise-arm bit is 1 sets that pin's capture bit. The bit then stays set until software clears it.
- R3: A high-to-low transition on a pin whose fall-arm bit is 1 sets that pin's capture bit.
- R4: A transition whose direction is not armed sets no capture bit and raises no interrupt. With only the rise-arm bit set, a falling edge leaves the capture register and `irq_o` unchanged.
- R5: Software can write a capture register to any value, including 0xFF. Writing back the read value ANDed with the complement of the handled bits clears exactly those bits.
- R6: Group 3 implements only pin 3. Its arm and capture registers read 0x08 after 0xFF is written.
- R7: The summary bit (control bit 1) is read-only. A control write does not change it and does not change any capture bit.
- R8: If a capture-register write that clears a bit coincides with a new armed transition on that pin, the bit is left set.
- R9: The summary bit is the OR of all capture bits, and `irq_o` equals summary AND enable (control bit 0).
- R10: With the default two-stage synchronizer, a pin change made between clock edges is visible in the capture register after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 32 | Asynchronous pin levels; group g occupies bits 8g+7..8g |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register address (group in [3:2], kind in [1:0]) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is R8. The clearing write must sit on exactly the clock where the delayed transition reaches the capture register, which is three edges after the pin moves. The bench changes the pin at a falling clock edge, counts two rising edges, and asserts the write strobe for the third. It then checks that the captured bit survived. A control case with the same write and no transition confirms that the write on its own does clear the bit.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  typedef enum logic [1:0] {
    K_RISE = 2'd0,
    K_FALL = 2'd1,
    K_CAPT = 2'd2,
    K_CTRL = 2'd3
  } reg_kind_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SUM_BIT = 1;
endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;
  logic [W-1:0]             level;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign level = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;
endmodule

// File: rtl/pcirq_group.sv
module pcirq_group #(
  parameter int           W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic         we_rise,
  input  logic         we_fall,
  input  logic         we_capt,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rise_arm_q,
  output logic [W-1:0] fall_arm_q,
  output logic [W-1:0] capt_q
);
  logic [W-1:0] hits;
  logic [W-1:0] capt_base;

  assign hits      = ((rise_i & rise_arm_q) | (fall_i & fall_arm_q)) & MASK;
  assign capt_base = we_capt ? wdata : capt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_arm_q <= '0;
      fall_arm_q <= '0;
      capt_q     <= '0;
    end else begin
      if (we_rise) rise_arm_q <= wdata & MASK;
      if (we_fall) fall_arm_q <= wdata & MASK;
      capt_q <= (capt_base & MASK) | hits;
    end
  end

  // Armed rising transitions must appear in the capture bits, even under a write (R2, R8)
  p_rise_captured_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_i & rise_arm_q & MASK) != '0) |=>
      ((capt_q & $past(rise_i & rise_arm_q & MASK)) == $past(rise_i & rise_arm_q & MASK)));

  // Armed falling transitions must appear in the capture bits (R3, R8)
  p_fall_captured_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_i & fall_arm_q & MASK) != '0) |=>
      ((capt_q & $past(fall_i & fall_arm_q & MASK)) == $past(fall_i & fall_arm_q & MASK)));

  // Without a write, a capture bit may only rise from an armed transition (R4)
  p_no_stray_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_capt |=> ((capt_q & ~$past(capt_q) & ~$past((rise_i & rise_arm_q) | (fall_i & fall_arm_q))) == '0));

  // Without a write, captured bits are sticky (R2)
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_capt |=> ((capt_q & $past(capt_q)) == $past(capt_q)));

  // Arm registers only move on their own write strobe (R4)
  p_arm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_rise && !we_fall) |=> ($stable(rise_arm_q) && $stable(fall_arm_q)));
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcirq_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_GROUPS*GROUP_W-1:0] IMPL_MASK = 32'h08FF_FFFF,
  localparam int SEL_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W = SEL_W + 2,
  localparam int PINS_W = NUM_GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PINS_W-1:0]  pins_i,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [GROUP_W-1:0] reg_wdata,
  output logic [GROUP_W-1:0] reg_rdata,
  output logic               irq_o
);
  logic [SEL_W-1:0] sel;
  reg_kind_e        kind;
  logic             sel_ok;
  logic             ctrl_hit;
  logic             irq_en_q;
  logic             summary;

  logic [NUM_GROUPS-1:0][GROUP_W-1:0] rise_arm_all;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] fall_arm_all;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] capt_all;

  assign sel      = reg_addr[ADDR_W-1:2];
  assign kind     = reg_kind_e'(reg_addr[1:0]);
  assign sel_ok   = (32'(sel) < NUM_GROUPS);
  assign ctrl_hit = (kind == K_CTRL) && (sel == '0);

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [GROUP_W-1:0] rise_w;
      logic [GROUP_W-1:0] fall_w;
      logic               hit_g;

      assign hit_g = reg_we && (32'(sel) == g);

      pcirq_sync #(.W(GROUP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins_i[g*GROUP_W +: GROUP_W]),
        .rise_o (rise_w),
        .fall_o (fall_w)
      );

      pcirq_group #(.W(GROUP_W), .MASK(IMPL_MASK[g*GROUP_W +: GROUP_W])) u_grp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise_w),
        .fall_i     (fall_w),
        .we_rise    (hit_g && (kind == K_RISE)),
        .we_fall    (hit_g && (kind == K_FALL)),
        .we_capt    (hit_g && (kind == K_CAPT)),
        .wdata      (reg_wdata),
        .rise_arm_q (rise_arm_all[g]),
        .fall_arm_q (fall_arm_all[g]),
        .capt_q     (capt_all[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  irq_en_q <= 1'b0;
    else if (reg_we && ctrl_hit) irq_en_q <= reg_wdata[CTRL_EN_BIT];
  end

  assign summary = |capt_all;
  assign irq_o   = summary & irq_en_q;

  always_comb begin
    reg_rdata = '0;
    if (sel_ok) begin
      unique case (kind)
        K_RISE: reg_rdata = rise_arm_all[sel];
        K_FALL: reg_rdata = fall_arm_all[sel];
        K_CAPT: reg_rdata = capt_all[sel];
        K_CTRL: if (ctrl_hit) begin
          reg_rdata[CTRL_EN_BIT]  = irq_en_q;
          reg_rdata[CTRL_SUM_BIT] = summary;
        end
      endcase
    end
  end

  // No capture bit set anywhere means no interrupt (R9)
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (capt_all == '0) |-> !irq_o);

  // A control write never clears captured bits (R7)
  p_ctrl_keeps_capt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ctrl_hit) |=> ((capt_all & $past(capt_all)) == $past(capt_all)));
endmodule

// File: tb/sim_pin_change_irq.sv
module sim_pin_change_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pin_change_irq u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // fields: [41:40] group, [39:32] rise arm, [31:24] fall arm,
  //         [23:16] level before, [15:8] level after, [7:0] expected capture
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 8'hFF, 8'h00, 8'h00, 8'h0F, 8'h0F},  // R2
    {2'd0, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00},  // R4
    {2'd1, 8'h00, 8'hFF, 8'hFF, 8'hF0, 8'h0F},  // R3
    {2'd1, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00},  // R4
    {2'd2, 8'h0F, 8'hF0, 8'h00, 8'hFF, 8'h0F},  // R2
    {2'd2, 8'h0F, 8'hF0, 8'hFF, 8'h00, 8'hF0},  // R3
    {2'd3, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h08},  // R6
    {2'd0, 8'hAA, 8'h55, 8'h0F, 8'hF0, 8'hA5}   // R2 R3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] ad(input int grp, input int k);
    return 4'(grp * 4 + k);
  endfunction

  initial begin : watchdog
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and the request line
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      check("R1", r, 8'h00);
    end
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // table walk: R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      int grp;
      grp = int'(VEC[v][41:40]);
      wr(ad(grp, 0), 8'h00);
      wr(ad(grp, 1), 8'h00);
      @(negedge clk);
      pins[grp*8 +: 8] = VEC[v][23:16];
      idle(5);
      wr(ad(grp, 0), VEC[v][39:32]);
      wr(ad(grp, 1), VEC[v][31:24]);
      wr(ad(grp, 2), 8'h00);
      @(negedge clk);
      pins[grp*8 +: 8] = VEC[v][15:8];
      idle(5);
      rd(ad(grp, 2), r);
      check($sformatf("R2/R3/R4/R6 vector %0d", v), r, VEC[v][7:0]);
    end
    for (int grp = 0; grp < 4; grp++) begin
      wr(ad(grp, 0), 8'h00); wr(ad(grp, 1), 8'h00); wr(ad(grp, 2), 8'h00);
    end
    @(negedge clk);
    pins = '0;
    idle(5);

    // R5: writable capture register and clear-by-AND-complement
    wr(ad(1, 2), 8'hFF); rd(ad(1, 2), r); check("R5 write ones", r, 8'hFF);
    wr(ad(1, 2), 8'hFF & ~8'h0C); rd(ad(1, 2), r); check("R5 and-clear", r, 8'hF3);
    wr(ad(1, 2), 8'h00); rd(ad(1, 2), r); check("R5 clear", r, 8'h00);

    // R6: group 3 implements only pin 3
    wr(ad(3, 0), 8'hFF); rd(ad(3, 0), r); check("R6 rise arm", r, 8'h08);
    wr(ad(3, 2), 8'hFF); rd(ad(3, 2), r); check("R6 capture", r, 8'h08);
    wr(ad(3, 0), 8'h00); wr(ad(3, 2), 8'h00);

    // R7: summary bit read-only; control write leaves captures alone
    wr(4'd3, 8'h03); rd(4'd3, r); check("R7 summary ignores write", r, 8'h01);
    wr(ad(0, 2), 8'h01); rd(4'd3, r); check("R9 summary and enable", r, 8'h03);
    check("R9 irq asserted", {7'd0, irq_o}, 8'h01);
    wr(4'd3, 8'h00); rd(4'd3, r); check("R7 summary survives write", r, 8'h02);
    rd(ad(0, 2), r); check("R7 capture kept", r, 8'h01);
    check("R9 irq masked", {7'd0, irq_o}, 8'h00);
    wr(4'd3, 8'h01); wr(ad(0, 2), 8'h00);
    rd(4'd3, r); check("R9 summary clear", r, 8'h01);
    check("R9 irq drops", {7'd0, irq_o}, 8'h00);

    // R4: rise-only arm, falling edge gives no capture and no request
    wr(ad(2, 0), 8'h01);
    @(negedge clk); pins[16] = 1'b1; idle(5);
    wr(ad(2, 2), 8'h00);
    @(negedge clk); pins[16] = 1'b0; idle(5);
    rd(ad(2, 2), r); check("R4 falling ignored", r, 8'h00);
    check("R4 irq quiet", {7'd0, irq_o}, 8'h00);
    wr(ad(2, 0), 8'h00);

    // R10: latency through synchronizer and capture register
    wr(ad(0, 0), 8'h01);
    wr(ad(0, 2), 8'h00);
    reg_addr = ad(0, 2);
    @(negedge clk); pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    #1 check("R10 not after two edges", reg_rdata, 8'h00);
    @(negedge clk);
    #1 check("R10 set after three edges", reg_rdata, 8'h01);
    check("R10 irq follows", {7'd0, irq_o}, 8'h01);

    // R8: clearing write on the same clock as a new armed edge
    @(negedge clk); pins[0] = 1'b0; idle(5);
    wr(ad(0, 2), 8'h01);
    @(negedge clk); pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_we = 1'b1; reg_addr = ad(0, 2); reg_wdata = 8'h00;
    @(negedge clk); reg_we = 1'b0;
    rd(ad(0, 2), r); check("R8 edge beats clear", r, 8'h01);
    wr(ad(0, 2), 8'h00);
    rd(ad(0, 2), r); check("R8 plain clear works", r, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule